// File: doc/BRIEF.md
# Alternating Way Selector for a Two-Way Data TLB

This block chooses which way of a two-way set-associative data TLB receives a new translation on a refill. The way hint coming from the TLB cannot be trusted, because it names way 1 every time. The block therefore keeps its own single history bit for each TLB set. Each refill to a set writes the way that the previous refill to that set did not write. The result is least-recently-written replacement within each set. A hit never changes the history. Only a refill does.

A refill is requested with a one-cycle strobe together with the effective address that missed. Load misses and store misses use the same strobe. The set is taken from five address bits. One clock after the strobe, the chosen way is presented with a valid flag. When the enable control is low, the block is a plain registered pass-through of the hint. A table-clear strobe returns every history bit to zero in one cycle, for example after the whole TLB has been invalidated.

Top module: `tlb_way_alternator`

## Requirements
- R1: After reset `wayValid` is 0 and every history bit is 0, so the first enabled refill to any set chooses way 1.
- R2: The set index is `missAddr[19:15]` (bit 0 is the least significant). Addresses that differ only outside those bits share one history bit, and each of the 32 sets has its own bit.
- R3: On an enabled refill whose set bit is 0, `wayOut` is 1 and the set bit becomes 1.
- R4: On an enabled refill whose set bit is 1, `wayOut` is 0 and the set bit becomes 0.
- R5: `wayValid` is 1 in exactly the cycle after each cycle in which `refillReq` is 1, and 0 otherwise. `wayOut` is updated in that same cycle.
- R6: Refills to the same set on consecutive cycles still alternate the way: 1, 0, 1, 0 starting from a cleared bit.
- R7: While `altEnable` is 1, `hwWayHint` has no effect on `wayOut` or on the history.
- R8: While `altEnable` is 0, a refill returns `hwWayHint` on `wayOut` and leaves every history bit unchanged.
- R9: Cycles without `refillReq` leave every history bit unchanged.
- R10: A `tableClear` strobe without a refill sets all 32 history bits to 0 by the next cycle. This happens whatever the value of `altEnable`.
- R11: When `tableClear` and an enabled refill coincide, the refill reads a cleared bit and so chooses way 1. Afterwards only that set's bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refillReq | input | 1 | One-cycle strobe that requests a way for a data-side refill |
| missAddr | input | 32 | Effective address that missed |
| hwWayHint | input | 1 | Way suggested by the TLB logic |
| altEnable | input | 1 | 1: alternate the ways by history; 0: pass the hint through |
| tableClear | input | 1 | Clears all history bits |
| wayOut | output | 1 | Chosen way, meaningful while wayValid is 1 |
| wayValid | output | 1 | Chosen way valid, one cycle after refillReq |

## Verification
The history bits are internal, so a corrupted bit appears at the ports only on the next refill to that same set. At that point `wayOut` shows the inverse of the expected way, one cycle after the strobe. A refill that updated the wrong set, or that updated a set while disabled, stays hidden until that other set is refilled. For this reason the bench refills every set again after each disabled, idle and clear phase, and it keeps a full reference table while it drives random traffic. Timing errors appear directly as `wayValid` one cycle early, one cycle late or missing.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
  // Strobes passed from the control module to the datapath module
  typedef struct packed {
    logic capture;    // latch a chosen way this cycle
    logic writeEn;    // update the history bit of the indexed set
    logic clearAll;   // clear the whole history store
    logic useHistory; // pick the way from history rather than from the hint
  } wselCtrl_t;
endpackage

// File: rtl/wsel_ctrl.sv
module wsel_ctrl
  import wsel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refillReq,
  input  logic      altEnable,
  input  logic      tableClear,
  output wselCtrl_t strobe,
  output logic      wayValid
);
  logic validQ;

  always_comb begin
    strobe.capture    = refillReq;
    strobe.writeEn    = refillReq & altEnable;
    strobe.clearAll   = tableClear;
    strobe.useHistory = altEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= refillReq;
  end

  assign wayValid = validQ;

  // R5: a valid way follows every refill strobe
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |=> wayValid);
  // R5: no valid way without a strobe in the previous cycle
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !refillReq |=> !wayValid);
endmodule

// File: rtl/wsel_datapath.sv
module wsel_datapath
  import wsel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 15,
  parameter int SETS    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wselCtrl_t         strobe,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              hwWayHint,
  output logic              wayOut
);
  localparam int IDX_W = $clog2(SETS);

  logic [SETS-1:0]  histQ;
  logic [IDX_W-1:0] setIdx;
  logic             curBit;
  logic             chosenWay;
  logic             wayQ;

  assign setIdx = missAddr[IDX_LSB +: IDX_W];

  // A clear in the same cycle makes the refill read a zero bit
  assign curBit    = strobe.clearAll ? 1'b0 : histQ[setIdx];
  assign chosenWay = strobe.useHistory ? ~curBit : hwWayHint;

  for (genvar s = 0; s < SETS; s++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN)
        histQ[s] <= 1'b0;
      else if (strobe.writeEn && (setIdx == IDX_W'(s)))
        histQ[s] <= ~curBit;
      else if (strobe.clearAll)
        histQ[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               wayQ <= 1'b0;
    else if (strobe.capture) wayQ <= chosenWay;
  end

  assign wayOut = wayQ;

  // R2: the address must be known whenever a refill is requested
  a_r2_addr_known: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !$isunknown(missAddr));
  // R9: the history holds when there is neither a write nor a clear
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeEn && !strobe.clearAll) |=> $stable(histQ));
  // R10: a clear alone empties the history store
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearAll && !strobe.writeEn) |=> (histQ == '0));
  // R11: a clear together with a refill leaves exactly one bit set
  a_r11_clear_refill: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearAll && strobe.writeEn) |=> ($countones(histQ) == 1));
  // R3, R4: an enabled refill inverts the bit of its set
  a_r4_bit_inverts: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && !strobe.clearAll) |=>
      (histQ[$past(setIdx)] != $past(histQ[setIdx])));
  // R8: in bypass the registered way equals the hint
  a_r8_bypass_hint: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.useHistory) |=> (wayOut == $past(hwWayHint)));
  // R3: a zero bit gives way 1
  a_r3_zero_gives_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && !curBit) |=> wayOut);
endmodule

// File: rtl/tlb_way_alternator.sv
module tlb_way_alternator
  import wsel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 15,
  parameter int SETS    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refillReq,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              hwWayHint,
  input  logic              altEnable,
  input  logic              tableClear,
  output logic              wayOut,
  output logic              wayValid
);
  wselCtrl_t strobe;

  wsel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refillReq  (refillReq),
    .altEnable  (altEnable),
    .tableClear (tableClear),
    .strobe     (strobe),
    .wayValid   (wayValid)
  );

  wsel_datapath #(
    .ADDR_W  (ADDR_W),
    .IDX_LSB (IDX_LSB),
    .SETS    (SETS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .missAddr  (missAddr),
    .hwWayHint (hwWayHint),
    .wayOut    (wayOut)
  );
endmodule

// File: tb/tlb_way_alternator_tb.sv
`timescale 1ns/1ps
module tlb_way_alternator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refillReq = 1'b0;
  logic [31:0] missAddr = '0;
  logic        hwWayHint = 1'b0;
  logic        altEnable = 1'b1;
  logic        tableClear = 1'b0;
  logic        wayOut;
  logic        wayValid;

  int nChecks = 0;
  int nFails  = 0;
  bit expHist [32];

  always #10 clk = ~clk;

  tlb_way_alternator u_dut (
    .clk(clk), .rstN(rstN), .refillReq(refillReq), .missAddr(missAddr),
    .hwWayHint(hwWayHint), .altEnable(altEnable), .tableClear(tableClear),
    .wayOut(wayOut), .wayValid(wayValid)
  );

  function automatic int setOf(input logic [31:0] a);
    return int'(a[19:15]);
  endfunction

  function automatic logic addrFor(input int s, input logic [31:0] noise);
    return 1'b0;
  endfunction

  function automatic logic [31:0] mkAddr(input int s, input logic [31:0] noise);
    logic [31:0] a;
    a = noise;
    a[19:15] = 5'(s);
    return a;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check after the next rising edge
  task automatic step(input logic req, input logic [31:0] addr, input logic hint,
                      input logic en, input logic clr, input string tag);
    logic expWay;
    int s;
    s = setOf(addr);
    refillReq = req; missAddr = addr; hwWayHint = hint;
    altEnable = en; tableClear = clr;
    expWay = 1'b0;
    if (clr) foreach (expHist[i]) expHist[i] = 1'b0;
    if (req) begin
      if (en) begin
        expWay = ~expHist[s];
        expHist[s] = ~expHist[s];
      end else begin
        expWay = hint;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, wayValid, req);
    if (req) check({tag, " way"}, wayOut, expWay);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b0, "R9 idle");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1F2E3D4C));
    foreach (expHist[i]) expHist[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", wayValid, 1'b0);
    rstN = 1'b1;

    // R1, R2: every set starts at zero, so the first refill to each gives way 1
    for (int s = 0; s < 32; s++) step(1'b1, mkAddr(s, $urandom), 1'b1, 1'b1, 1'b0, "R1 R2 first fill");
    // R4: the second round gives way 0 in every set
    for (int s = 0; s < 32; s++) step(1'b1, mkAddr(s, $urandom), 1'b1, 1'b1, 1'b0, "R4 second fill");

    // R6: back-to-back refills to set 9 with different bits outside the index
    for (int i = 0; i < 4; i++) step(1'b1, mkAddr(9, 32'h0000_1000 * i), 1'b1, 1'b1, 1'b0, "R6 R2 back-to-back");

    // R7: the hint is ignored while enabled
    step(1'b1, mkAddr(3, 0), 1'b0, 1'b1, 1'b0, "R7 hint0");
    step(1'b1, mkAddr(3, 0), 1'b1, 1'b1, 1'b0, "R7 hint1");
    step(1'b1, mkAddr(3, 0), 1'b0, 1'b1, 1'b0, "R7 hint0 again");

    // R8: bypass passes the hint and does not touch the table
    for (int i = 0; i < 6; i++) step(1'b1, mkAddr(i, 0), 1'(i & 1), 1'b0, 1'b0, "R8 bypass");
    for (int s = 0; s < 6; s++) step(1'b1, mkAddr(s, 0), 1'b1, 1'b1, 1'b0, "R8 table unchanged");

    // R9: idle cycles leave the table as it was
    idle(10);
    for (int s = 0; s < 32; s++) step(1'b1, mkAddr(s, 0), 1'b0, 1'b1, 1'b0, "R9 after idle");

    // R10: a clear while disabled still resets all bits
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, "R10 clear");
    for (int s = 0; s < 32; s++) step(1'b1, mkAddr(s, 0), 1'b1, 1'b1, 1'b0, "R10 after clear");

    // R11: clear and refill in one cycle
    step(1'b1, mkAddr(7, 0), 1'b1, 1'b1, 1'b1, "R11 clear+fill");
    for (int s = 0; s < 32; s++) step(1'b1, mkAddr(s, 0), 1'b0, 1'b1, 1'b0, "R11 after clear+fill");

    // R3 R4 R5 R6 R8 R9 R10: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic r, e, c;
      r = ($urandom % 4) != 0;
      e = ($urandom % 8) != 0;
      c = ($urandom % 64) == 0;
      step(r, mkAddr($urandom % 32, $urandom), 1'($urandom), e, c, "R3 R4 R5 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule